// File: doc/BRIEF.md
# Dual-Rail Self-Timed Ripple Adder with Carry-Biased Indication

This block adds two N-bit words plus a carry-in. Every bit travels on a pair of rails: the true rail high means 1, the false rail high means 0, and both rails low is the spacer (no data). Both rails high is never legal. Operands arrive as valid data and then return to spacer, alternately. Each rail may arrive on its own schedule, and the block needs no word-level strobe. The sum rails of a bit leave spacer only once every input of that bit is valid: its A bit, its B bit and its incoming carry. They return to spacer only once all of those inputs are spacer again. A downstream completion detector can therefore watch the sum rails alone.

The carry rails are deliberately relaxed. A cell whose two operand bits are equal (generate or kill) drives its carry out without waiting for the carry in. A propagating cell passes the incoming carry straight through an AND-OR gate. Every cell drops its carry back to spacer as soon as its operand bits are spacer, whether or not the carry in has cleared. Carries therefore ripple only across the active chain and reset in about one cell delay.

The design is a discrete-time model. Each Muller C-element is a two-state machine that moves at the clock edge, so one clock stands for one C-element delay. The OR and AND-OR gates are combinational and take zero time. Each C-element has two states, `C_LOW` and `C_HIGH`. The transition *rise* (`C_LOW` to `C_HIGH`) happens when both inputs are 1. The transition *fall* (`C_HIGH` to `C_LOW`) happens when both inputs are 0. Every other input combination is a *hold*.

Top module: `dr_weak_rca`

## Requirements
- R1: Every C-element rises only when both of its inputs were 1 at the preceding edge. It falls only when both were 0. Otherwise it holds its state.
- R2: While rst_n is low, and at the first edge after rst_n goes high, every output rail is 0 (spacer).
- R3: With all inputs valid, the result settles within two clocks of the last input arriving. Reading true rail = 1 and false rail = 0, {cout, sum} then equals A + B + cin.
- R4: No sum or carry rail pair ever has both rails at 1.
- R5: Sum bit i becomes valid only after A[i], B[i] and its incoming carry are all valid. It becomes valid exactly two clocks after the last of A[i] and B[i] arrives, provided its carry is already valid. While only some of these inputs are present, the sum rails stay 0.
- R6: A valid sum bit holds its value until A[i], B[i] and its incoming carry have all returned to spacer. It reaches spacer one clock after the last of them does.
- R7: A cell with A[i] = B[i] (generate when both are 1, kill when both are 0) drives its carry out, equal to A[i], one clock after both operand bits arrive, with no carry in present.
- R8: A cell with A[i] different from B[i] (propagate) passes its carry in to its carry out in the same cycle once its operand bits have been latched.
- R9: A carry out returns to spacer one clock after both operand bits of its cell are spacer, even while the carry in is still valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model time step; one period equals one C-element delay |
| rst_n | input | 1 | Active-low reset; forces every C-element to C_LOW |
| a_t | input | WIDTH | Operand A, true rails |
| a_f | input | WIDTH | Operand A, false rails |
| b_t | input | WIDTH | Operand B, true rails |
| b_f | input | WIDTH | Operand B, false rails |
| cin_t | input | 1 | Carry in, true rail |
| cin_f | input | 1 | Carry in, false rail |
| sum_t | output | WIDTH | Sum, true rails |
| sum_f | output | WIDTH | Sum, false rails |
| cout_t | output | 1 | Carry out, true rail |
| cout_f | output | 1 | Carry out, false rail |

## Verification
The bench sweeps every combination of A, B and cin on a 4-bit instance, using two arrival orders. In the first order the operands arrive before the carry in. This shows which sum bits and carry out can resolve from generate or kill cells alone, and which must wait for the carry in. In the second order the carry in arrives first. Here the bench drops the carry in before the operands, which shows that the sums hold while the carries may clear. Comparing the moment the carries clear with the moment the sums clear separates the relaxed carry path from the fully indicating sum path.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic {
        C_LOW  = 1'b0,
        C_HIGH = 1'b1
    } c_state_e;

endpackage

// File: rtl/dr_celem.sv
module dr_celem
    import dr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    output logic z
);

    c_state_e state_q;
    c_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_LOW:  if (x && y)   state_d = C_HIGH;   // rise
            C_HIGH: if (!x && !y) state_d = C_LOW;    // fall
            default: state_d = C_LOW;
        endcase
    end

    always_comb begin
        z = (state_q == C_HIGH);
    end

    p_rise_both_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(z) |-> $past(x && y));

    p_fall_both_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(z) |-> $past(!x && !y));

endmodule

// File: rtl/dr_fa_cell.sv
module dr_fa_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic a_t,
    input  logic a_f,
    input  logic b_t,
    input  logic b_f,
    input  logic cin_t,
    input  logic cin_f,
    output logic sum_t,
    output logic sum_f,
    output logic cout_t,
    output logic cout_f
);

    logic m_f_t;   // A=0, B=1
    logic m_t_f;   // A=1, B=0
    logic m_gen;   // A=1, B=1
    logic m_kil;   // A=0, B=0
    logic prop;
    logic eqv;
    logic s_eq_c1, s_pr_c0, s_eq_c0, s_pr_c1;

    dr_celem u_mft (.clk(clk), .rst_n(rst_n), .x(a_f), .y(b_t), .z(m_f_t));
    dr_celem u_mtf (.clk(clk), .rst_n(rst_n), .x(a_t), .y(b_f), .z(m_t_f));
    dr_celem u_gen (.clk(clk), .rst_n(rst_n), .x(a_t), .y(b_t), .z(m_gen));
    dr_celem u_kil (.clk(clk), .rst_n(rst_n), .x(a_f), .y(b_f), .z(m_kil));

    assign prop = m_f_t | m_t_f;
    assign eqv  = m_gen | m_kil;

    dr_celem u_eq1 (.clk(clk), .rst_n(rst_n), .x(eqv),  .y(cin_t), .z(s_eq_c1));
    dr_celem u_pr0 (.clk(clk), .rst_n(rst_n), .x(prop), .y(cin_f), .z(s_pr_c0));
    dr_celem u_eq0 (.clk(clk), .rst_n(rst_n), .x(eqv),  .y(cin_f), .z(s_eq_c0));
    dr_celem u_pr1 (.clk(clk), .rst_n(rst_n), .x(prop), .y(cin_t), .z(s_pr_c1));

    assign sum_t = s_eq_c1 | s_pr_c0;
    assign sum_f = s_eq_c0 | s_pr_c1;

    // input-incomplete AND-OR carry gates
    assign cout_t = (prop & cin_t) | m_gen;
    assign cout_f = (prop & cin_f) | m_kil;

    p_sum_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sum_t && sum_f));

    p_cout_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cout_t && cout_f));

    p_sum_rise_after_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_t || sum_f) |-> $past((cin_t || cin_f) && (prop || eqv)));

    p_sum_fall_after_cin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sum_t || sum_f) |-> $past(!cin_t && !cin_f));

    p_cout_needs_operands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_t || cout_f) |-> $past(a_t || a_f || b_t || b_f));

endmodule

// File: rtl/dr_weak_rca.sv
module dr_weak_rca #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    input  logic             cin_t,
    input  logic             cin_f,
    output logic [WIDTH-1:0] sum_t,
    output logic [WIDTH-1:0] sum_f,
    output logic             cout_t,
    output logic             cout_f
);

    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] car_t;
    logic [CHAIN-1:0] car_f;

    assign car_t[0] = cin_t;
    assign car_f[0] = cin_f;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dr_fa_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_t    (a_t[i]),
            .a_f    (a_f[i]),
            .b_t    (b_t[i]),
            .b_f    (b_f[i]),
            .cin_t  (car_t[i]),
            .cin_f  (car_f[i]),
            .sum_t  (sum_t[i]),
            .sum_f  (sum_f[i]),
            .cout_t (car_t[i+1]),
            .cout_f (car_f[i+1])
        );
    end

    assign cout_t = car_t[WIDTH];
    assign cout_f = car_f[WIDTH];

    p_outputs_spacer_at_reset_r2: assert property (@(posedge clk)
        !rst_n |=> (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f));

endmodule

// File: tb/dr_weak_rca_tb_top.sv
module dr_weak_rca_tb_top;

    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic cin_t = 1'b0, cin_f = 1'b0;
    logic [W-1:0] sum_t, sum_f;
    logic cout_t, cout_f;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dr_weak_rca #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .cin_t(cin_t), .cin_f(cin_f),
        .sum_t(sum_t), .sum_f(sum_f),
        .cout_t(cout_t), .cout_f(cout_f)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // R4: rail exclusivity sampled every cycle
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(((sum_t & sum_f) == '0) && !(cout_t && cout_f), "R4 rail pair 1,1",
                {sum_t & sum_f, 3'b0, cout_t & cout_f}, 0);
    end

    function automatic logic [31:0] outs();
        return {8'(sum_t), 8'(sum_f), 7'd0, cout_t, 7'd0, cout_f};
    endfunction

    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input int ord);
        logic [W:0] full;
        logic [W:0] kn;
        logic [W-1:0] km;
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        kn[0] = 1'b0;
        for (int i = 0; i < W; i++) kn[i+1] = (a[i] == b[i]) | kn[i];
        km = kn[W-1:0];
        if (ord == 0) begin
            @(negedge clk); a_t = a; a_f = ~a;
            @(negedge clk);
            chk(outs() == 0, "R5 only A present", outs(), 0);
            @(negedge clk);
            chk(outs() == 0, "R5 only A present", outs(), 0);
            b_t = b; b_f = ~b;
            @(negedge clk);
            chk((cout_t | cout_f) == kn[W], "R7 carry without cin", {cout_t, cout_f}, kn[W]);
            if (kn[W]) chk(cout_t == full[W], "R7 carry value", cout_t, full[W]);
            chk((sum_t | sum_f) == '0, "R5 sum waits one more clock", sum_t | sum_f, 0);
            @(negedge clk);
            chk((sum_t | sum_f) == km, "R5 sum valid only where carry known", sum_t | sum_f, km);
            chk((sum_t & km) == (full[W-1:0] & km), "R5 resolved sum value", sum_t & km, full[W-1:0] & km);
            cin_t = c; cin_f = ~c;
            #1;
            chk(cout_t == full[W] && cout_f == !full[W], "R8 carry ripples same cycle",
                {cout_t, cout_f}, {full[W], !full[W]});
            @(negedge clk); @(negedge clk);
            chk(sum_t == full[W-1:0] && sum_f == ~full[W-1:0], "R3 sum value", sum_t, full[W-1:0]);
            chk(cout_t == full[W] && cout_f == !full[W], "R3 carry out", {cout_t, cout_f}, {full[W], !full[W]});
            a_t = '0; a_f = '0; b_t = '0; b_f = '0;
            @(negedge clk);
            chk(!cout_t && !cout_f, "R9 carry reset with cin valid", {cout_t, cout_f}, 0);
            chk(sum_t == full[W-1:0] && sum_f == ~full[W-1:0], "R6 sums hold", sum_t, full[W-1:0]);
            @(negedge clk);
            chk((sum_t | sum_f) == W'(1), "R6 bit0 holds for cin", sum_t | sum_f, 1);
            chk(sum_t[0] == full[0], "R1 hold keeps value", sum_t[0], full[0]);
            cin_t = 1'b0; cin_f = 1'b0;
            @(negedge clk);
            chk(outs() == 0, "R6 all spacer", outs(), 0);
        end else begin
            @(negedge clk); cin_t = c; cin_f = ~c;
            @(negedge clk);
            chk(outs() == 0, "R5 only cin present", outs(), 0);
            a_t = a; a_f = ~a;
            @(negedge clk);
            chk(outs() == 0, "R5 B missing", outs(), 0);
            b_t = b; b_f = ~b;
            @(negedge clk);
            chk(cout_t == full[W] && cout_f == !full[W], "R8 carry after operands",
                {cout_t, cout_f}, {full[W], !full[W]});
            chk((sum_t | sum_f) == '0, "R5 sum two clocks", sum_t | sum_f, 0);
            @(negedge clk);
            chk(sum_t == full[W-1:0] && sum_f == ~full[W-1:0], "R3 sum value", sum_t, full[W-1:0]);
            cin_t = 1'b0; cin_f = 1'b0;
            @(negedge clk);
            chk(sum_t == full[W-1:0] && sum_f == ~full[W-1:0], "R6 sums hold while A B valid",
                sum_t, full[W-1:0]);
            a_t = '0; a_f = '0; b_t = '0; b_f = '0;
            @(negedge clk);
            chk(!cout_t && !cout_f, "R9 carry reset", {cout_t, cout_f}, 0);
            chk((sum_t | sum_f) == '1, "R6 sums one clock later", sum_t | sum_f, '1);
            @(negedge clk);
            chk(outs() == 0, "R6 all spacer", outs(), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(outs() == 0, "R2 spacer during reset", outs(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 0, "R2 spacer after reset", outs(), 0);
        for (int ord = 0; ord < 2; ord++) begin
            for (int v = 0; v < (1 << (2 * W + 1)); v++) begin
                logic [2*W:0] vv;
                vv = (2 * W + 1)'(v);
                run_vec(vv[W-1:0], vv[2*W-1:W], vv[2*W], ord);
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule